// File: doc/BRIEF.md
# Continuous-Level Serial Break Detector

This block watches an asynchronous serial receive line on every oversample, at sixteen times the bit rate. It tells a genuine BREAK apart from two look-alikes. One is a NUL character whose stop bit was missed. The other is a line that rings or toggles faster than the bit rate. Only an unbroken SPACE level counts. The detector measures how long the SPACE lasted. It then watches the MARK that follows. A break is confirmed only when both durations are long enough. Recovering character data is left to a separate receiver running alongside it.

The line is brought in through a two-flop synchronizer. A per-sample enable `os_tick` marks the oversamples; the block ignores the line on cycles without the enable. The configuration inputs give the data width and whether a parity bit is present. The character frame length F in bit times and the break threshold T are derived from them. All results are plain single-cycle pulses, plus a measured duration that is held until the next long SPACE run ends. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `brk_detect`

## Requirements
- R1: Reset drives all four pulse outputs low, clears `space_bits` to 0 and treats the line as MARK. A level change on `rx_line` takes effect on the second clock edge after it is applied, because it first passes through two synchronizer flops.
- R2: The frame length is F = 2 + D + P bit times. D = 5 + `cfg_dsel`, where codes 0..3 select 5..8 data bits. P = `cfg_par_en` (1 adds a parity bit). The break threshold is T = 2*(D+P) + 3 bit times, so 8 data bits without parity give F = 10 and T = 19, and 7 data bits give F = 9 and T = 17.
- R3: `break_start` pulses for one cycle on the oversample where the line has been SPACE (0) for 16*F consecutive samples. A single MARK sample restarts the count, so toggling shorter than a frame never raises it.
- R4: Only cycles with `os_tick` high are samples. Cycles without it neither advance nor restart any count.
- R5: `break_end` pulses for one cycle on the first MARK sample that follows a `break_start`.
- R6: When `break_end` fires, `space_bits` takes the SPACE run length in samples divided by 16 and rounded down. If the value exceeds 2^SPACE_W-1 it saturates there.
- R7: A SPACE run of at least 16*F samples but fewer than 16*T samples is a misframed NUL. For such a run, `nul_misframed` pulses together with `break_end`.
- R8: After a run of at least 16*T SPACE samples, `break_valid` pulses on the 16*T-th consecutive MARK sample. Any SPACE sample before that point cancels the confirmation.
- R9: The run counters saturate instead of wrapping. A very long SPACE raises `break_start` exactly once.
- R10: `break_start`, `break_end` and `break_valid` never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial line, 1 = MARK, 0 = SPACE |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| cfg_dsel | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present in each frame |
| break_start | output | 1 | Pulse: a full frame of unbroken SPACE has been seen |
| break_end | output | 1 | Pulse: first MARK after a start-of-break |
| break_valid | output | 1 | Pulse: genuine break confirmed |
| nul_misframed | output | 1 | Pulse: the SPACE run was only a misframed NUL |
| space_bits | output | SPACE_W | Last measured SPACE run length in bit times |

## Verification
With `os_tick` held high, suppose SPACE is applied right after edge c0. Then `break_start` is visible after edge c0+2+16*F. Suppose MARK returns right after edge c1. Then `break_end`, and `nul_misframed` where it applies, are visible after edge c1+3, and `space_bits` changes on that same edge. `break_valid` follows on the 16*T-th MARK sample after that. The directed tests compare the recorded pulse cycles against these sums. The random runs count pulses and read `space_bits` only after a MARK stretch of at least eight samples, or after a trailing idle period that is longer than every one of these latencies.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic {
    Q_WATCH = 1'b0,
    Q_HOLD  = 1'b1
  } qstate_e;

  // frame length in bit times: start + data + parity + stop
  function automatic logic [4:0] frame_len(input logic [1:0] dsel, input logic par);
    return 5'd7 + {3'd0, dsel} + {4'd0, par};
  endfunction

  // break threshold in bit times: twice the character width plus three
  function automatic logic [4:0] brk_len(input logic [1:0] dsel, input logic par);
    return 5'd13 + {2'd0, dsel, 1'b0} + {3'd0, par, 1'b0};
  endfunction

endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/brk_run_cnt.sv
module brk_run_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         active,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      if (!active)        cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brk_qual.sv
module brk_qual
  import brk_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int OSR_LG  = 4,
  parameter int SPACE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rx_s,
  input  logic [CNT_W-1:0]   space_cnt,
  input  logic [CNT_W-1:0]   mark_cnt,
  input  logic [CNT_W-1:0]   frm_tk,
  input  logic [CNT_W-1:0]   brk_tk,
  output logic               start_p,
  output logic               end_p,
  output logic               valid_p,
  output logic               nul_p,
  output logic [SPACE_W-1:0] space_bits
);
  qstate_e st;
  logic    long_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= Q_WATCH;
      long_run   <= 1'b0;
      start_p    <= 1'b0;
      end_p      <= 1'b0;
      valid_p    <= 1'b0;
      nul_p      <= 1'b0;
      space_bits <= '0;
    end else begin
      start_p <= 1'b0;
      end_p   <= 1'b0;
      valid_p <= 1'b0;
      nul_p   <= 1'b0;
      if (tick) begin
        if (!rx_s) begin
          // any space sample cancels a pending confirmation
          if (st == Q_HOLD) st <= Q_WATCH;
          if (space_cnt == frm_tk - 1'b1) begin
            start_p  <= 1'b1;
            long_run <= 1'b1;
          end
        end else if (long_run) begin
          end_p      <= 1'b1;
          long_run   <= 1'b0;
          space_bits <= space_cnt[CNT_W-1:OSR_LG];
          if (space_cnt >= brk_tk) st    <= Q_HOLD;
          else                     nul_p <= 1'b1;
        end else if (st == Q_HOLD && mark_cnt == brk_tk - 1'b1) begin
          valid_p <= 1'b1;
          st      <= Q_WATCH;
        end
      end
    end
  end
endmodule

// File: rtl/brk_detect.sv
module brk_detect
  import brk_pkg::*;
#(
  parameter int SPACE_W = 12,
  parameter int OSR     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_line,
  input  logic               os_tick,
  input  logic [1:0]         cfg_dsel,
  input  logic               cfg_par_en,
  output logic               break_start,
  output logic               break_end,
  output logic               break_valid,
  output logic               nul_misframed,
  output logic [SPACE_W-1:0] space_bits
);
  localparam int OSR_LG = $clog2(OSR);
  localparam int CNT_W  = SPACE_W + OSR_LG;

  logic             rx_s;
  logic [CNT_W-1:0] space_cnt;
  logic [CNT_W-1:0] mark_cnt;
  logic [CNT_W-1:0] frm_tk;
  logic [CNT_W-1:0] brk_tk;

  assign frm_tk = {{(CNT_W-5){1'b0}}, frame_len(cfg_dsel, cfg_par_en)} << OSR_LG;
  assign brk_tk = {{(CNT_W-5){1'b0}}, brk_len(cfg_dsel, cfg_par_en)} << OSR_LG;

  brk_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  brk_run_cnt #(.W(CNT_W)) u_space (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .active(~rx_s), .cnt(space_cnt)
  );

  brk_run_cnt #(.W(CNT_W)) u_mark (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .active(rx_s), .cnt(mark_cnt)
  );

  brk_qual #(.CNT_W(CNT_W), .OSR_LG(OSR_LG), .SPACE_W(SPACE_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s),
    .space_cnt(space_cnt), .mark_cnt(mark_cnt),
    .frm_tk(frm_tk), .brk_tk(brk_tk),
    .start_p(break_start), .end_p(break_end), .valid_p(break_valid),
    .nul_p(nul_misframed), .space_bits(space_bits)
  );
endmodule

// File: rtl/brk_chk.sv
module brk_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             os_tick,
  input logic             rx_s,
  input logic [CNT_W-1:0] space_cnt,
  input logic             break_start,
  input logic             break_end,
  input logic             break_valid,
  input logic             nul_misframed
);
  logic seen_start;

  always_ff @(posedge clk) begin
    if (!rst_n)           seen_start <= 1'b0;
    else if (break_start) seen_start <= 1'b1;
    else if (break_end)   seen_start <= 1'b0;
  end

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    break_start |=> !break_start);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !os_tick |=> $stable(space_cnt));

  assert_end_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    break_end |-> seen_start);

  assert_nul_with_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nul_misframed |-> break_end);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && !rx_s && space_cnt != '0) |=> (space_cnt != '0));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({break_start, break_end, break_valid}));
endmodule

bind brk_detect brk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_s(rx_s),
  .space_cnt(space_cnt), .break_start(break_start), .break_end(break_end),
  .break_valid(break_valid), .nul_misframed(nul_misframed)
);

// File: tb/tb_brk_detect.sv
module tb_brk_detect;
  localparam int CLK_P = 10;
  localparam int SW    = 6;
  localparam int SATV  = (1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_line = 1'b1;
  logic          os_tick = 1'b1;
  logic [1:0]    dsel = 2'd3;
  logic          par = 1'b0;
  logic          gate = 1'b0;
  logic          b_st, b_en, b_va, b_nu;
  logic [SW-1:0] sbits;

  int cyc = 0;
  int n_st = 0, n_en = 0, n_va = 0, n_nu = 0;
  int last_st = 0, last_en = 0;
  int nchk = 0, nfail = 0;

  brk_detect #(.SPACE_W(SW), .OSR(16)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_dsel(dsel), .cfg_par_en(par),
    .break_start(b_st), .break_end(b_en), .break_valid(b_va),
    .nul_misframed(b_nu), .space_bits(sbits)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (b_st) begin n_st++; last_st = cyc; end
    if (b_en) begin n_en++; last_en = cyc; end
    if (b_va) n_va++;
    if (b_nu) n_nu++;
    if (gate) os_tick <= ~os_tick;
    else      os_tick <= 1'b1;
  end

  function automatic int f_frame(int d, int p);
    return 7 + d + p;
  endfunction

  function automatic int f_brk(int d, int p);
    return 13 + 2 * d + 2 * p;
  endfunction

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic seg(logic lvl, int n);
    rx_line = lvl;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr();
    n_st = 0; n_en = 0; n_va = 0; n_nu = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int c0, c1, exp_sb;
    void'($urandom(32'd2718));
    // R1: reset state
    repeat (5) @(negedge clk);
    #1;
    check("R1 start low in reset", int'(b_st), 0);
    check("R1 valid low in reset", int'(b_va), 0);
    check("R1 space_bits reset", int'(sbits), 0);
    rst_n = 1'b1;
    seg(1'b1, 20);
    check("R1 no pulses on idle mark", n_st + n_en + n_va + n_nu, 0);

    // R1/R3/R5/R7: latency and misframed NUL, 8 data bits no parity
    clr(); c0 = cyc;
    seg(1'b0, 250);
    c1 = cyc;
    seg(1'b1, 400);
    check("R3 start latency", last_st, c0 + 2 + 160);
    check("R5 end latency", last_en, c1 + 3);
    check("R7 nul on 15-bit space", n_nu, 1);
    check("R8 no valid after nul", n_va, 0);
    check("R6 space_bits 15", int'(sbits), 15);

    // R3: toggling shorter than a frame
    clr();
    seg(1'b0, 159); seg(1'b1, 1); seg(1'b0, 159); seg(1'b1, 50);
    check("R3 toggle no start", n_st, 0);

    // R7/R8: threshold edges
    clr();
    seg(1'b0, 303); seg(1'b1, 400);
    check("R7 303 samples is nul", n_nu, 1);
    check("R7 303 samples no valid", n_va, 0);
    check("R6 space_bits 18", int'(sbits), 18);
    clr();
    seg(1'b0, 304); seg(1'b1, 304); seg(1'b1, 20);
    check("R8 304 samples valid", n_va, 1);
    check("R8 304 samples not nul", n_nu, 0);
    check("R6 space_bits 19", int'(sbits), 19);
    clr();
    seg(1'b0, 304); seg(1'b1, 303); seg(1'b0, 5); seg(1'b1, 50);
    check("R8 cancel by space", n_va, 0);

    // R2: other frame formats
    dsel = 2'd2; par = 1'b0;
    clr();
    seg(1'b0, 143); seg(1'b1, 20);
    check("R2 7-bit 143 no start", n_st, 0);
    seg(1'b0, 144); seg(1'b1, 20);
    check("R2 7-bit 144 start", n_st, 1);
    check("R2 7-bit nul", n_nu, 1);
    dsel = 2'd0; par = 1'b1;
    clr();
    seg(1'b0, 240); seg(1'b1, 240); seg(1'b1, 10);
    check("R2 5-bit parity valid", n_va, 1);

    // R4: gated samples, 8 data bits
    dsel = 2'd3; par = 1'b0;
    gate = 1'b1;
    clr();
    seg(1'b0, 280); seg(1'b1, 20);
    check("R4 half-rate 140 no start", n_st, 0);
    seg(1'b0, 360); seg(1'b1, 20);
    check("R4 half-rate start", n_st, 1);
    check("R4 half-rate space_bits", int'(sbits), 11);
    gate = 1'b0;
    seg(1'b1, 10);

    // R9/R6: saturation
    clr();
    seg(1'b0, 1200); seg(1'b1, 400);
    check("R9 single start on long space", n_st, 1);
    check("R6 space_bits saturate", int'(sbits), SATV);
    check("R8 valid after long space", n_va, 1);

    // random runs
    exp_sb = SATV;
    for (int it = 0; it < 5; it++) begin
      int d, p, ft, tt, e_st, e_nu, e_va;
      d = int'($urandom_range(0, 3)); p = int'($urandom_range(0, 1));
      dsel = 2'(d); par = 1'(p);
      ft = 16 * f_frame(d, p); tt = 16 * f_brk(d, p);
      clr(); e_st = 0; e_nu = 0; e_va = 0;
      for (int k = 0; k < 8; k++) begin
        int s, m, cat;
        cat = int'($urandom_range(0, 2));
        if (cat == 0)      s = int'($urandom_range(1, ft - 1));
        else if (cat == 1) s = int'($urandom_range(ft, tt - 1));
        else               s = int'($urandom_range(tt, tt + 300));
        if (k == 7 || $urandom_range(0, 1) == 1) m = int'($urandom_range(tt, tt + 100));
        else                                     m = int'($urandom_range(8, tt - 1));
        seg(1'b0, s); seg(1'b1, m);
        if (s >= ft) begin
          e_st++;
          exp_sb = (s / 16 > SATV) ? SATV : s / 16;
          if (s < tt) e_nu++;
          else if (m >= tt) e_va++;
        end
        check("R6 random space_bits", int'(sbits), exp_sb);
      end
      seg(1'b1, 20);
      check("R3 random start count", n_st, e_st);
      check("R5 random end count", n_en, e_st);
      check("R7 random nul count", n_nu, e_nu);
      check("R8 random valid count", n_va, e_va);
    end
    summary();
  end
endmodule